// File: doc/BRIEF.md
# Controller Low-Power Sequencer

This block controls power-down entry and recovery for a disk-controller-style peripheral. It drives the enable of the internal oscillator and the ready-for-host status bit (request-for-master) that the host polls before it issues command bytes. The oscillator, the data separator and command execution live outside this block.

Power-down can be requested in two ways. A host write to the data-rate control register can set its low-power bit. A mode-command write can also request it, and the manual request is the OR of these two sources. Power-down can also start by itself when automatic mode is enabled and the controller has stayed idle for a programmable number of prescaled ticks. The block leaves power-down when the host reads or writes the data or status register, or when software issues a reset from either control register. Leaving power-down restarts the oscillator and holds the ready bit low for a configurable settling time. After that the ready bit rises and operation continues with the stored settings.

Top module: `lp_sequencer`

## Requirements
- R1: While reset is asserted, `osc_en_o`=1, `rqm_o`=0 and `dsr_lp_o`=0. After reset is released, `rqm_o` stays 0 for STABLE_CYCLES-1 clock edges and reads 1 after STABLE_CYCLES edges.
- R2: In the running state, a data-rate write (`dsr_wr_i`) whose low-power bit `dsr_lp_bit_i` (bit 6 of the register) is 1 makes `osc_en_o`=0, `rqm_o`=0 and `dsr_lp_o`=1 after the next clock edge.
- R3: In the running state, a mode write (`mode_wr_i`) with `mode_lp_bit_i`=1 enters power-down on the next edge in the same way. The manual request is the OR of this bit and the data-rate bit.
- R4: In power-down, `osc_en_o` and `rqm_o` stay 0 for as long as no wake event occurs.
- R5: In power-down, a pulse on `host_acc_i` makes `osc_en_o`=1 on the next edge. `rqm_o` then stays 0 for STABLE_CYCLES edges after that one, and reads 1 one edge later.
- R6: In power-down, a pulse on `dsr_srst_i` or on `dor_srst_i` wakes the block with the same timing as R5.
- R7: A wake event in power-down clears both manual low-power bits (`dsr_lp_o` reads 0 on the next edge). It takes priority over a data-rate write in the same cycle.
- R8: With auto mode set (a mode write with `mode_auto_bit_i`=1), `idle_i` held high in the running state for IDLE_TICKS*TICK_DIV edges leaves `rqm_o`=1. One edge later the block is in power-down.
- R9: Dropping `idle_i` for one cycle before the timeout restarts the idle count from zero. With auto mode clear, idle never causes power-down.
- R10: Auto mode stays armed across wake-ups. After a wake with `idle_i` still high, power-down follows IDLE_TICKS*TICK_DIV+1 edges after `rqm_o` rises, and auto mode does not have to be written again.
- R11: A host access or a software reset while running has no effect: `rqm_o` and `osc_en_o` stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Controller is in its idle state |
| host_acc_i | input | 1 | Host read or write of the data or status register |
| dsr_wr_i | input | 1 | Write strobe of the data-rate register |
| dsr_lp_bit_i | input | 1 | Low-power bit (bit 6) of the data-rate write data |
| mode_wr_i | input | 1 | Mode-command write strobe |
| mode_lp_bit_i | input | 1 | Mode-command manual low-power bit |
| mode_auto_bit_i | input | 1 | Mode-command automatic low-power enable |
| dsr_srst_i | input | 1 | Software reset issued through the data-rate register |
| dor_srst_i | input | 1 | Software reset issued through the digital-output register |
| osc_en_o | output | 1 | Oscillator / internal clock enable |
| rqm_o | output | 1 | Request-for-master status bit |
| dsr_lp_o | output | 1 | Readback of the data-rate low-power bit |

## Verification
The hardest case to reach from the ports is the automatic re-arm. The controller has to stay idle through a whole wake-up, and the idle count must restart only once the ready bit is back. The stimulus sets auto mode once, holds `idle_i` high and wakes the block with a host access. It then expects a second power-down at an exact cycle counted from the wake pulse, without rewriting the mode. A second hard case is the restart of the idle count: the stimulus drops idle for a single cycle near the middle of the interval and expects the full interval again. A wake event that coincides with a data-rate write checks that the wake takes priority.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_WAKE = 2'd2
  } lp_state_e;
endpackage

// File: rtl/lp_tick_gen.sv
module lp_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] div_q;

  assign tick_o = en_i && (div_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
  parameter int unsigned TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(TICKS + 1);

  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == W'(TICKS));

  // saturates at TICKS; any drop of en_i restarts the interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!en_i)                  cnt_q <= '0;
    else if (tick_i && !expired_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lp_settle_timer.sv
module lp_settle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == W'(CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lp_sequencer.sv
module lp_sequencer
  import lp_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 4,
  parameter int unsigned IDLE_TICKS    = 25,
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic host_acc_i,
  input  logic dsr_wr_i,
  input  logic dsr_lp_bit_i,
  input  logic mode_wr_i,
  input  logic mode_lp_bit_i,
  input  logic mode_auto_bit_i,
  input  logic dsr_srst_i,
  input  logic dor_srst_i,
  output logic osc_en_o,
  output logic rqm_o,
  output logic dsr_lp_o
);
  lp_state_e st_q, st_d;

  logic wake;
  logic dsr_lp_q, dsr_lp_d;
  logic mode_lp_q, mode_lp_d;
  logic auto_q;
  logic lp_req;
  logic timer_en, tick, idle_expired;
  logic settle_en, settle_done;

  assign wake = host_acc_i | dsr_srst_i | dor_srst_i;

  // manual bits: a wake event out of power-down clears them and beats a write
  always_comb begin
    dsr_lp_d  = dsr_lp_q;
    mode_lp_d = mode_lp_q;
    if (st_q == ST_DOWN && wake) begin
      dsr_lp_d  = 1'b0;
      mode_lp_d = 1'b0;
    end else begin
      if (dsr_wr_i)  dsr_lp_d  = dsr_lp_bit_i;
      if (mode_wr_i) mode_lp_d = mode_lp_bit_i;
    end
  end

  assign lp_req = dsr_lp_d | mode_lp_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsr_lp_q  <= 1'b0;
      mode_lp_q <= 1'b0;
      auto_q    <= 1'b0;
    end else begin
      dsr_lp_q  <= dsr_lp_d;
      mode_lp_q <= mode_lp_d;
      if (mode_wr_i) auto_q <= mode_auto_bit_i;
    end
  end

  assign timer_en  = idle_i && (st_q == ST_RUN);
  assign settle_en = (st_q == ST_WAKE);

  lp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (timer_en),
    .tick_o (tick)
  );

  lp_idle_timer #(.TICKS(IDLE_TICKS)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (timer_en),
    .tick_i    (tick),
    .expired_o (idle_expired)
  );

  lp_settle_timer #(.CYCLES(STABLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (settle_en),
    .done_o (settle_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (lp_req || (auto_q && idle_expired)) st_d = ST_DOWN;
      ST_DOWN: if (wake) st_d = ST_WAKE;
      ST_WAKE: if (settle_done) st_d = lp_req ? ST_DOWN : ST_RUN;
      default: st_d = ST_WAKE;
    endcase
  end

  // hardware reset behaves like a fresh oscillator start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WAKE;
    else         st_q <= st_d;
  end

  assign osc_en_o = (st_q != ST_DOWN);
  assign rqm_o    = (st_q == ST_RUN);
  assign dsr_lp_o = dsr_lp_q;
endmodule

// File: rtl/lp_sequencer_chk.sv
module lp_sequencer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic idle_i,
  input logic host_acc_i,
  input logic dsr_wr_i,
  input logic dsr_lp_bit_i,
  input logic mode_wr_i,
  input logic mode_lp_bit_i,
  input logic dsr_srst_i,
  input logic dor_srst_i,
  input logic osc_en_o,
  input logic rqm_o,
  input logic dsr_lp_o
);
  logic wk;
  assign wk = host_acc_i | dsr_srst_i | dor_srst_i;

  assert_down_no_rqm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !rqm_o);

  assert_down_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !wk) |=> !osc_en_o);

  assert_dsr_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rqm_o && dsr_wr_i && dsr_lp_bit_i && !wk) |=> (!osc_en_o && !rqm_o && dsr_lp_o));

  assert_mode_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rqm_o && mode_wr_i && mode_lp_bit_i && !wk) |=> (!osc_en_o && !rqm_o));

  assert_wake_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && wk) |=> (osc_en_o && !rqm_o && !dsr_lp_o));

  assert_ready_after_osc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rqm_o) |-> $past(osc_en_o));

  assert_run_wake_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rqm_o && wk && !dsr_wr_i && !mode_wr_i && !idle_i) |=> (rqm_o && osc_en_o));
endmodule

bind lp_sequencer lp_sequencer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idle_i       (idle_i),
  .host_acc_i   (host_acc_i),
  .dsr_wr_i     (dsr_wr_i),
  .dsr_lp_bit_i (dsr_lp_bit_i),
  .mode_wr_i    (mode_wr_i),
  .mode_lp_bit_i(mode_lp_bit_i),
  .dsr_srst_i   (dsr_srst_i),
  .dor_srst_i   (dor_srst_i),
  .osc_en_o     (osc_en_o),
  .rqm_o        (rqm_o),
  .dsr_lp_o     (dsr_lp_o)
);

// File: tb/lp_sequencer_bench.sv
`timescale 1ns/1ps
module lp_sequencer_bench;
  localparam int D = 4;
  localparam int N = 25;
  localparam int S = 16;
  localparam int ND = N * D;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic idle_i = 1'b0, host_acc_i = 1'b0, dsr_wr_i = 1'b0, dsr_lp_bit_i = 1'b0;
  logic mode_wr_i = 1'b0, mode_lp_bit_i = 1'b0, mode_auto_bit_i = 1'b0;
  logic dsr_srst_i = 1'b0, dor_srst_i = 1'b0;
  logic osc_en_o, rqm_o, dsr_lp_o;

  always #2.5 clk_i = ~clk_i;

  lp_sequencer #(.TICK_DIV(D), .IDLE_TICKS(N), .STABLE_CYCLES(S)) u_lp_sequencer (
    .clk_i, .rst_ni, .idle_i, .host_acc_i, .dsr_wr_i, .dsr_lp_bit_i,
    .mode_wr_i, .mode_lp_bit_i, .mode_auto_bit_i, .dsr_srst_i, .dor_srst_i,
    .osc_en_o, .rqm_o, .dsr_lp_o
  );

  typedef struct {
    int    cyc;
    logic  rqm;
    logic  osc;
    logic  dsr;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic cmp(input logic r, input logic o, input logic d, input exp_t e);
    total++;
    if (r !== e.rqm || o !== e.osc || d !== e.dsr) begin
      bad++;
      $display("FAIL %s cyc=%0d actual rqm=%b osc=%b dsr=%b expected rqm=%b osc=%b dsr=%b",
               e.tag, cyc, r, o, d, e.rqm, e.osc, e.dsr);
    end
  endtask

  // driver side: queue an expectation k edges from now
  task automatic expect_at(input int k, input logic r, input logic o, input logic d,
                           input string tag);
    exp_t e;
    e.cyc = cyc + k; e.rqm = r; e.osc = o; e.dsr = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cyc < cyc) begin
        total++; bad++;
        $display("FAIL %s stale expectation cyc=%0d actual cyc=%0d", e.tag, e.cyc, cyc);
      end else begin
        cmp(rqm_o, osc_en_o, dsr_lp_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    exp_t e0;
    step(3);
    e0.cyc = cyc; e0.rqm = 1'b0; e0.osc = 1'b1; e0.dsr = 1'b0; e0.tag = "R1 reset state";
    cmp(rqm_o, osc_en_o, dsr_lp_o, e0);
    rst_ni = 1'b1;
    expect_at(S - 1, 1'b0, 1'b1, 1'b0, "R1 still settling");
    expect_at(S,     1'b1, 1'b1, 1'b0, "R1 ready after settle");
    step(S + 2);

    // R2 manual entry via data-rate bit
    dsr_wr_i = 1'b1; dsr_lp_bit_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b1, "R2 data-rate low power");
    step(1);
    dsr_wr_i = 1'b0; dsr_lp_bit_i = 1'b0;
    expect_at(10, 1'b0, 1'b0, 1'b1, "R4 stays down");
    step(11);

    // R5 wake by host access
    host_acc_i = 1'b1;
    expect_at(1,     1'b0, 1'b1, 1'b0, "R5 osc restarts, R7 bit cleared");
    expect_at(S,     1'b0, 1'b1, 1'b0, "R5 ready held low");
    expect_at(S + 1, 1'b1, 1'b1, 1'b0, "R5 ready");
    step(1);
    host_acc_i = 1'b0;
    step(S + 2);

    // R3 manual entry via mode bit, R6 wake by data-rate soft reset
    mode_wr_i = 1'b1; mode_lp_bit_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R3 mode low power");
    step(1);
    mode_wr_i = 1'b0; mode_lp_bit_i = 1'b0;
    step(5);
    dsr_srst_i = 1'b1;
    expect_at(1,     1'b0, 1'b1, 1'b0, "R6 dsr reset wakes");
    expect_at(S + 1, 1'b1, 1'b1, 1'b0, "R6 ready after dsr reset");
    step(1);
    dsr_srst_i = 1'b0;
    step(S + 2);

    // R6 wake by digital-output soft reset
    mode_wr_i = 1'b1; mode_lp_bit_i = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R3 mode low power again");
    step(1);
    mode_wr_i = 1'b0; mode_lp_bit_i = 1'b0;
    step(4);
    dor_srst_i = 1'b1;
    expect_at(1,     1'b0, 1'b1, 1'b0, "R6 dor reset wakes");
    expect_at(S,     1'b0, 1'b1, 1'b0, "R6 dor ready held low");
    expect_at(S + 1, 1'b1, 1'b1, 1'b0, "R6 ready after dor reset");
    step(1);
    dor_srst_i = 1'b0;
    step(S + 2);

    // R11 wake events while running
    host_acc_i = 1'b1; dsr_srst_i = 1'b1;
    expect_at(1,     1'b1, 1'b1, 1'b0, "R11 access while running");
    expect_at(S + 2, 1'b1, 1'b1, 1'b0, "R11 still running");
    step(1);
    host_acc_i = 1'b0; dsr_srst_i = 1'b0;
    step(S + 3);

    // R9 auto disabled: long idle keeps running
    idle_i = 1'b1;
    expect_at(ND + 5, 1'b1, 1'b1, 1'b0, "R9 no auto when disabled");
    step(ND + 6);
    idle_i = 1'b0;
    step(2);

    // R8 auto entry
    mode_wr_i = 1'b1; mode_auto_bit_i = 1'b1;
    step(1);
    mode_wr_i = 1'b0; mode_auto_bit_i = 1'b0;
    idle_i = 1'b1;
    expect_at(ND,     1'b1, 1'b1, 1'b0, "R8 before timeout");
    expect_at(ND + 1, 1'b0, 1'b0, 1'b0, "R8 auto power-down");
    step(ND + 2);

    // R10 wake with idle still high re-arms without a new mode write
    host_acc_i = 1'b1;
    expect_at(S + 1,      1'b1, 1'b1, 1'b0, "R10 ready after wake");
    expect_at(S + 1 + ND, 1'b1, 1'b1, 1'b0, "R10 before second timeout");
    expect_at(S + 2 + ND, 1'b0, 1'b0, 1'b0, "R10 re-armed power-down");
    step(1);
    host_acc_i = 1'b0;
    step(S + 2 + ND);

    // R9 idle drop restarts the count
    host_acc_i = 1'b1; idle_i = 1'b0;
    expect_at(S + 1, 1'b1, 1'b1, 1'b0, "R9 ready before restart test");
    step(1);
    host_acc_i = 1'b0;
    step(S + 1);
    idle_i = 1'b1;
    step(60);
    idle_i = 1'b0;
    step(1);
    idle_i = 1'b1;
    expect_at(ND,     1'b1, 1'b1, 1'b0, "R9 count restarted");
    expect_at(ND + 1, 1'b0, 1'b0, 1'b0, "R9 full interval after restart");
    step(ND + 2);

    // R7 wake beats a simultaneous data-rate write
    idle_i = 1'b0;
    host_acc_i = 1'b1; dsr_wr_i = 1'b1; dsr_lp_bit_i = 1'b1;
    expect_at(1,     1'b0, 1'b1, 1'b0, "R7 wake wins over write");
    expect_at(S + 1, 1'b1, 1'b1, 1'b0, "R7 ready, no re-entry");
    step(1);
    host_acc_i = 1'b0; dsr_wr_i = 1'b0; dsr_lp_bit_i = 1'b0;
    step(S + 3);

    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL pending expectations actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule